// File: doc/BRIEF.md
# Linear-Mode Serial Flash Read Engine

This engine makes one or two multi-line serial flash devices look like a read-only memory. A client gives a 25-bit byte address and a read request. The engine then runs a complete flash read transaction in hardware, with no software step for each access. It asserts the select, drives the serial clock, and shifts out the command byte and the 24-bit device address. It inserts the dummy clocks when the command needs them. It then collects the returned bits and delivers them as one 32-bit word with a one-cycle valid strobe.

Three wirings sit behind the same flat address space:
- a single device;
- two stacked devices that share one group of data lines, where address bit 24 picks the device;
- two parallel devices that each carry half of every byte, so that one serial clock delivers a full byte when four lines per device are used.

The number of data lines per device can be one, two or four. This choice selects the read command and whether dummy clocks are needed.

The serial clock runs at half the system clock. Each serial clock is one low system cycle followed by one high system cycle.

Top module: `flash_read_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, both selects are high (`flash_cs_n` = 2'b11) and `flash_sclk` is 0.
- R2: The command byte is sent on `flash_mosi`, MSB first, one bit per serial clock. The command depends on `cfg_lines`: 0 (one line) sends 0x03, 1 (two lines) sends 0x3B, and 2 or 3 (four lines) sends 0x6B.
- R3: A 24-bit device address follows the command on `flash_mosi`, MSB first. For single and stacked wiring it is `req_addr[23:0]`. For single wiring, address bit 24 has no effect.
- R4: With two or four lines, 8 dummy clocks follow the address. With one line there are none. A transaction has 32 + dummy + 32/(lines × devices) serial clocks in total.
- R5: `cfg_wiring` 1 (stacked) asserts only `flash_cs_n[0]` when `req_addr[24]` is 0, and only `flash_cs_n[1]` when it is 1. `cfg_wiring` 0 (single, and 3 treated the same) asserts only `flash_cs_n[0]`.
- R6: `cfg_wiring` 2 (parallel) asserts both selects together and sends both devices the address `req_addr[24:1]`. The lower device (`flash_io_in[3:0]`) supplies the low nibble of each byte and the upper device (`flash_io_in[7:4]`) supplies the high nibble.
- R7: Data is sampled on each rising serial clock edge after the dummy phase, MSB first within each device's line group. One-line mode reads line 1 of the group. Two-line mode reads lines 1:0, with line 1 carrying the earlier bit. Four-line mode reads lines 3:0, with line 3 carrying the most significant bit.
- R8: The first received byte goes to `rsp_data[7:0]`, and later bytes go to successively higher bytes (little-endian).
- R9: When the last serial clock ends, the selects are released. In the next cycle `rsp_valid` is high for exactly one cycle, with `flash_cs_n` = 2'b11 and `flash_sclk` = 0.
- R10: A request is accepted only while `req_ready` is 1. `req_ready` stays 0 from acceptance until the response cycle is over, and requests made in that window are ignored.
- R11: `flash_sclk` never rises while both selects are high, and it is never high in two consecutive system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 25 | Byte address of the word to read |
| cfg_wiring | input | 2 | Wiring: 0 single, 1 stacked, 2 parallel, 3 as single |
| cfg_lines | input | 2 | Data lines per device: 0 one, 1 two, 2 or 3 four |
| req_ready | output | 1 | Engine idle, request may be presented |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Little-endian read word |
| flash_sclk | output | 1 | Serial clock to the devices |
| flash_cs_n | output | 2 | Active-low device selects, bit 0 lower device |
| flash_mosi | output | 1 | Command and address line, shared by both devices |
| flash_io_in | input | 8 | Returned data, [3:0] lower device, [7:4] upper device |

## Verification
The assertions assume that `cfg_wiring` and `cfg_lines` matter only in the cycle a request is accepted. They also assume that the devices present each data group before the rising serial edge that samples it. The bench's flash models update their lines a short delay after each falling serial edge that follows the dummy phase, and they stay silent while deselected. The bench drives requests only at falling system clock edges and changes the configuration only while the engine is idle. The one deliberate violation is a request raised while the engine is busy, which checks that such a request is ignored.

// File: rtl/flr_pkg.sv
package flr_pkg;

    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int FRAME_BITS = CMD_BITS + ADDR_BITS;
    localparam int DUMMY_CLKS = 8;
    localparam int WORD_BITS  = 32;
    localparam int GROUP_W    = 4;
    localparam int CNT_W      = $clog2(FRAME_BITS + DUMMY_CLKS + WORD_BITS + 1);

    typedef enum logic [1:0] {
        WIRING_SINGLE   = 2'd0,
        WIRING_STACKED  = 2'd1,
        WIRING_PARALLEL = 2'd2,
        WIRING_RSVD     = 2'd3
    } wiring_e;

    typedef enum logic [1:0] {
        LINES_1    = 2'd0,
        LINES_2    = 2'd1,
        LINES_4    = 2'd2,
        LINES_RSVD = 2'd3
    } lines_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic                  parallel;
        lines_e                lines;
        logic [1:0]            sel;
        logic [FRAME_BITS-1:0] frame;
        logic [CNT_W-1:0]      total;
        logic [CNT_W-1:0]      data_first;
    } job_t;

    function automatic logic [7:0] opcode_for(lines_e l);
        case (l)
            LINES_1: return 8'h03;
            LINES_2: return 8'h3B;
            default: return 8'h6B;
        endcase
    endfunction

    function automatic int unsigned width_of(lines_e l);
        case (l)
            LINES_1: return 1;
            LINES_2: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic job_t plan_job(wiring_e w, lines_e l, logic [ADDR_BITS:0] addr);
        job_t        j;
        lines_e      ln;
        int unsigned wd;
        int unsigned devs;
        int unsigned dum;
        ln   = (l == LINES_RSVD) ? LINES_4 : l;
        wd   = width_of(ln);
        dum  = (ln == LINES_1) ? 0 : DUMMY_CLKS;
        j.parallel = (w == WIRING_PARALLEL);
        devs = j.parallel ? 2 : 1;
        j.lines = ln;
        case (w)
            WIRING_PARALLEL: j.sel = 2'b11;
            WIRING_STACKED:  j.sel = addr[ADDR_BITS] ? 2'b10 : 2'b01;
            default:         j.sel = 2'b01;
        endcase
        j.frame      = {opcode_for(ln), j.parallel ? addr[ADDR_BITS:1] : addr[ADDR_BITS-1:0]};
        j.data_first = CNT_W'(FRAME_BITS + dum);
        j.total      = CNT_W'(FRAME_BITS + dum + WORD_BITS / (wd * devs));
        return j;
    endfunction

endpackage

// File: rtl/flr_seq.sv
module flr_seq
    import flr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] total,
    output logic          active,
    output logic          sclk,
    output logic          rise,
    output logic          last,
    output logic [CW-1:0] cnt
);
    logic half;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            half   <= 1'b0;
            sclk   <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            half   <= 1'b0;
            sclk   <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (!half) begin
                sclk <= 1'b1;
                half <= 1'b1;
            end else begin
                sclk <= 1'b0;
                half <= 1'b0;
                if (cnt == total - 1'b1) active <= 1'b0;
                else                     cnt    <= cnt + 1'b1;
            end
        end
    end

    assign rise = active && !half;
    assign last = active && half && (cnt == total - 1'b1);

    assert_sclk_short_high_R11: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

    assert_no_clock_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sclk);
endmodule

// File: rtl/flr_frame_tx.sv
module flr_frame_tx
    import flr_pkg::*;
#(
    parameter int FB = FRAME_BITS,
    parameter int CW = CNT_W
) (
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic [FB-1:0] frame,
    output logic          mosi
);
    localparam int IW = $clog2(FB);

    logic [IW-1:0] idx;

    always_comb begin
        idx  = IW'(FB - 1) - cnt[IW-1:0];
        mosi = 1'b0;
        if (active && (cnt < CW'(FB))) mosi = frame[idx];
    end
endmodule

// File: rtl/flr_collect.sv
module flr_collect
    import flr_pkg::*;
#(
    parameter int WB = WORD_BITS,
    parameter int GW = GROUP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          sample,
    input  lines_e        lines,
    input  logic          parallel,
    input  logic [2*GW-1:0] io_in,
    output logic [WB-1:0] word
);
    localparam int HB = WB / 2;
    localparam int NB = WB / 8;

    logic [WB-1:0] sr_lo;
    logic [HB-1:0] sr_hi;
    logic [GW-1:0] grp_lo;
    logic [GW-1:0] grp_hi;
    logic [WB-1:0] stream;

    assign grp_lo = io_in[GW-1:0];
    assign grp_hi = io_in[2*GW-1:GW];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_lo <= '0;
            sr_hi <= '0;
        end else if (sample) begin
            case (lines)
                LINES_1: begin
                    sr_lo <= {sr_lo[WB-2:0], grp_lo[1]};
                    sr_hi <= {sr_hi[HB-2:0], grp_hi[1]};
                end
                LINES_2: begin
                    sr_lo <= {sr_lo[WB-3:0], grp_lo[1:0]};
                    sr_hi <= {sr_hi[HB-3:0], grp_hi[1:0]};
                end
                default: begin
                    sr_lo <= {sr_lo[WB-5:0], grp_lo[3:0]};
                    sr_hi <= {sr_hi[HB-5:0], grp_hi[3:0]};
                end
            endcase
        end
    end

    always_comb begin
        stream = sr_lo;
        if (parallel) begin
            for (int i = 0; i < NB; i++) begin
                stream[WB-1-8*i -: 8] = {sr_hi[HB-1-4*i -: 4], sr_lo[HB-1-4*i -: 4]};
            end
        end
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_le
            assign word[8*b +: 8] = stream[WB-1-8*b -: 8];
        end
    endgenerate
endmodule

// File: rtl/flash_read_engine.sv
module flash_read_engine
    import flr_pkg::*;
#(
    parameter int AW = ADDR_BITS + 1,
    parameter int DW = WORD_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    cfg_wiring,
    input  logic [1:0]    cfg_lines,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          flash_sclk,
    output logic [1:0]    flash_cs_n,
    output logic          flash_mosi,
    input  logic [2*GROUP_W-1:0] flash_io_in
);
    eng_state_e       st;
    job_t             job;
    job_t             job_next;
    logic [1:0]       cs_sel;
    logic             start;
    logic             seq_active;
    logic             seq_rise;
    logic             seq_last;
    logic [CNT_W-1:0] seq_cnt;
    logic             sample;

    assign job_next = plan_job(wiring_e'(cfg_wiring), lines_e'(cfg_lines), req_addr);
    assign start    = (st == ST_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            job    <= '0;
            cs_sel <= 2'b00;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    job    <= job_next;
                    cs_sel <= job_next.sel;
                    st     <= ST_RUN;
                end
                ST_RUN: if (seq_last) begin
                    cs_sel <= 2'b00;
                    st     <= ST_RESP;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    flr_seq #(.CW(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .total  (job.total),
        .active (seq_active),
        .sclk   (flash_sclk),
        .rise   (seq_rise),
        .last   (seq_last),
        .cnt    (seq_cnt)
    );

    flr_frame_tx #(.FB(FRAME_BITS), .CW(CNT_W)) u_tx (
        .active (seq_active),
        .cnt    (seq_cnt),
        .frame  (job.frame),
        .mosi   (flash_mosi)
    );

    assign sample = seq_rise && (seq_cnt >= job.data_first);

    flr_collect #(.WB(DW), .GW(GROUP_W)) u_col (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .sample   (sample),
        .lines    (job.lines),
        .parallel (job.parallel),
        .io_in    (flash_io_in),
        .word     (rsp_data)
    );

    assign flash_cs_n = ~cs_sel;
    assign req_ready  = (st == ST_IDLE);
    assign rsp_valid  = (st == ST_RESP);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        seq_active |-> !req_ready);

    assert_release_at_resp_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (flash_cs_n == 2'b11) && !flash_sclk);

    assert_resp_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_sclk_needs_select_R11: assert property (@(posedge clk) disable iff (rst)
        flash_sclk |-> (flash_cs_n != 2'b11));

    assert_dual_select_parallel_R6: assert property (@(posedge clk) disable iff (rst)
        (flash_cs_n == 2'b00) |-> job.parallel);

    assert_select_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_active && !seq_last) |=> $stable(flash_cs_n));
endmodule

// File: tb/flash_read_engine_test.sv
module flash_read_engine_test;

    typedef struct {
        logic [31:0] word;
        logic [7:0]  op;
        logic [23:0] a;
        int          clocks;
        logic [1:0]  sel;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic [1:0]  cfg_wiring = 2'd0;
    logic [1:0]  cfg_lines = 2'd0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        sclk;
    logic [1:0]  cs_n;
    logic        mosi;
    logic [7:0]  io_in;
    logic        par_wiring = 1'b0;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   stray = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    flash_read_engine uut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .cfg_wiring  (cfg_wiring),
        .cfg_lines   (cfg_lines),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .flash_sclk  (sclk),
        .flash_cs_n  (cs_n),
        .flash_mosi  (mosi),
        .flash_io_in (io_in)
    );

    function automatic logic [7:0] mem_byte(int d, logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ (a[23:16] + 8'd3) ^ ((d != 0) ? 8'hA5 : 8'h3C);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    for (genvar d = 0; d < 2; d++) begin : g_dev
        int          edges = 0;
        int          wd = 1;
        int          pre = 1000;
        int          bits_left = 0;
        int          ntx = 0;
        int          last_edges = 0;
        logic [31:0] frame = '0;
        logic [7:0]  cur = '0;
        logic [23:0] ptr = '0;
        logic [7:0]  last_op = '0;
        logic [23:0] last_addr = '0;
        logic [3:0]  drive = '0;

        always @(posedge sclk) begin
            if (cs_n[d] === 1'b0) begin
                if (edges < 32) frame = {frame[30:0], mosi};
                edges = edges + 1;
                if (edges == 32) begin
                    case (frame[31:24])
                        8'h03:   begin wd = 1; pre = 32; end
                        8'h3B:   begin wd = 2; pre = 40; end
                        8'h6B:   begin wd = 4; pre = 40; end
                        default: begin wd = 1; pre = 1000; end
                    endcase
                    ptr = frame[23:0];
                    bits_left = 0;
                end
            end
        end

        always @(negedge sclk) begin
            if (cs_n[d] === 1'b0 && edges >= 32 && edges >= pre) begin
                #2;
                if (bits_left == 0) begin
                    cur = mem_byte(d, ptr);
                    ptr = ptr + 24'd1;
                    bits_left = 8;
                end
                case (wd)
                    1:       begin drive = {2'b00, cur[7], 1'b0}; cur = cur << 1; end
                    2:       begin drive = {2'b00, cur[7:6]};     cur = cur << 2; end
                    default: begin drive = cur[7:4];              cur = cur << 4; end
                endcase
                bits_left = bits_left - wd;
            end
        end

        always @(posedge cs_n[d]) begin
            if (edges > 0) begin
                last_op    = frame[31:24];
                last_addr  = frame[23:0];
                last_edges = edges;
                ntx        = ntx + 1;
            end
            edges = 0;
            pre   = 1000;
            drive = 4'h0;
        end
    end

    assign io_in[3:0] = (cs_n[0] === 1'b0) ? g_dev[0].drive :
                        ((cs_n[1] === 1'b0 && !par_wiring) ? g_dev[1].drive : 4'h0);
    assign io_in[7:4] = (par_wiring && cs_n[1] === 1'b0) ? g_dev[1].drive : 4'h0;

    always @(posedge sclk) if (cs_n === 2'b11) stray++;

    // Scoreboard monitor
    int   prev_tx0 = 0;
    int   prev_tx1 = 0;
    logic prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_rsp) check("R9 rsp_valid one cycle", {31'd0, rsp_valid}, 32'd0);
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    check("R10 unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    logic [1:0] hit;
                    e = q.pop_front();
                    hit = {g_dev[1].ntx != prev_tx1, g_dev[0].ntx != prev_tx0};
                    prev_tx0 = g_dev[0].ntx;
                    prev_tx1 = g_dev[1].ntx;
                    check("R8/R7 data word", rsp_data, e.word);
                    check("R5/R6 selected devices", {30'd0, hit}, {30'd0, e.sel});
                    check("R9 select released", {30'd0, cs_n}, 32'h3);
                    if (e.sel == 2'b10) begin
                        check("R2 opcode", {24'd0, g_dev[1].last_op}, {24'd0, e.op});
                        check("R3 address", {8'd0, g_dev[1].last_addr}, {8'd0, e.a});
                        check("R4 clock count", g_dev[1].last_edges, e.clocks);
                    end else begin
                        check("R2 opcode", {24'd0, g_dev[0].last_op}, {24'd0, e.op});
                        check("R3 address", {8'd0, g_dev[0].last_addr}, {8'd0, e.a});
                        check("R4 clock count", g_dev[0].last_edges, e.clocks);
                    end
                    if (e.sel == 2'b11) begin
                        check("R6 upper address", {8'd0, g_dev[1].last_addr}, {8'd0, e.a});
                        check("R6 upper clocks", g_dev[1].last_edges, e.clocks);
                    end
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    task automatic push_expect(logic [1:0] wir, logic [1:0] lin, logic [24:0] addr);
        exp_t        e;
        int          wd;
        int          devs;
        int          dum;
        int          dev;
        logic [7:0]  lb[2];
        logic [7:0]  hb[2];
        logic [3:0]  nl;
        logic [3:0]  nh;
        wd   = (lin == 2'd0) ? 1 : ((lin == 2'd1) ? 2 : 4);
        dum  = (lin == 2'd0) ? 0 : 8;
        e.op = (lin == 2'd0) ? 8'h03 : ((lin == 2'd1) ? 8'h3B : 8'h6B);
        devs = (wir == 2'd2) ? 2 : 1;
        e.clocks = 32 + dum + 32 / (wd * devs);
        if (wir == 2'd2) begin
            e.sel = 2'b11;
            e.a = addr[24:1];
            for (int j = 0; j < 2; j++) begin
                lb[j] = mem_byte(0, e.a + 24'(j));
                hb[j] = mem_byte(1, e.a + 24'(j));
            end
            for (int i = 0; i < 4; i++) begin
                nl = (i % 2 == 0) ? lb[i/2][7:4] : lb[i/2][3:0];
                nh = (i % 2 == 0) ? hb[i/2][7:4] : hb[i/2][3:0];
                e.word[8*i +: 8] = {nh, nl};
            end
        end else begin
            dev = (wir == 2'd1 && addr[24]) ? 1 : 0;
            e.sel = (dev == 1) ? 2'b10 : 2'b01;
            e.a = addr[23:0];
            for (int i = 0; i < 4; i++) e.word[8*i +: 8] = mem_byte(dev, e.a + 24'(i));
        end
        q.push_back(e);
    endtask

    task automatic do_read(logic [1:0] wir, logic [1:0] lin, logic [24:0] addr, bit poke_busy);
        while (!req_ready) @(negedge clk);
        cfg_wiring = wir;
        cfg_lines  = lin;
        par_wiring = (wir == 2'd2);
        req_addr   = addr;
        req_valid  = 1'b1;
        push_expect(wir, (lin == 2'd3) ? 2'd2 : lin, addr);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_busy) begin
            repeat (10) @(negedge clk);
            check("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
            req_addr  = addr ^ 25'h0F0F0F0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        check("watchdog expired", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 cs_n", {30'd0, cs_n}, 32'h3);
        check("R1 sclk", {31'd0, sclk}, 32'd0);

        do_read(2'd0, 2'd0, 25'h0000100, 1'b0);
        do_read(2'd0, 2'd1, 25'h1ABCDE4, 1'b0);
        do_read(2'd0, 2'd2, 25'h0123450, 1'b0);
        do_read(2'd0, 2'd3, 25'h0FEDCB8, 1'b0);
        do_read(2'd1, 2'd2, 25'h0345678, 1'b0);
        do_read(2'd1, 2'd2, 25'h1345678, 1'b0);
        do_read(2'd1, 2'd0, 25'h1000004, 1'b0);
        do_read(2'd1, 2'd1, 25'h0FFFFFC, 1'b0);
        do_read(2'd2, 2'd2, 25'h0246810, 1'b0);
        do_read(2'd2, 2'd1, 25'h1FFFFF8, 1'b0);
        do_read(2'd2, 2'd0, 25'h0000020, 1'b0);
        do_read(2'd0, 2'd2, 25'h0055AA0, 1'b1);

        repeat (200) @(negedge clk);
        check("R10 ignored busy request left no job", q.size(), 0);
        check("R11 sclk while deselected", stray, 0);
        check("R11 idle cs_n", {30'd0, cs_n}, 32'h3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule